// File: doc/BRIEF.md
# Byte-Write Synchronous SRAM Access Controller

This block is the access controller for a synchronous SRAM with a shared data bus. The memory is 36 bits wide and takes a 19-bit address. All of its inputs are sampled on one clock edge. It decodes the following inputs:

- two address strobes: one from a memory controller and one from a processor;
- three chip enables;
- a global write;
- a byte-write enable and four per-lane byte selects;
- a burst advance;
- an output enable.

From these it drives write strobes and lane masks into a register-array model of the storage core. It registers read data and controls the output driver of the shared bus. The core holds `2**CORE_AW` words and is indexed by the low `CORE_AW` address bits. The register array is there only for simulation.

A strobe cycle loads the external address into two places: the high-order address register and a separate two-bit burst sequencer. In that same cycle the address is applied to the core. After the strobe, each cycle with the advance input low steps the sequencer through four word offsets, in either linear or interleaved order. A write started by the controller strobe finishes in the cycle it is presented. Any cycle that presents a write combination forces the bus drivers to high impedance, whatever the output enable says.

Top module: `bwsram_ctrl`

## Requirements
- R1: After reset, `dqOe` is 0, the burst offset is cleared and every core word reads back as zero.
- R2: A cycle with `adscN`=0, `adspN`=1, all three `ceN` bits 0 and a write combination present writes the core word at `addr` on that clock edge. A read of that word in the next cycle returns the new data.
- R3: When `adspN`=0, the strobe loads the address and no write happens, whatever `gwN`, `bweN` and `bwN` are. If selected, that cycle is a read.
- R4: A strobe cycle with any `ceN` bit at 1 deselects the device. Until the next selecting strobe, no write takes place, no read data is produced and `dqOe` stays 0.
- R5: `gwN`=0 writes all four lanes, whatever `bweN` and `bwN` are.
- R6: With `gwN`=1 and `bweN`=0, lane k (bits 9k+8 down to 9k) is written only when `bwN[k]`=0, and every other lane keeps its old value. With `gwN`=1 and `bweN`=1, no write takes place and the cycle is a read.
- R7: In any cycle where a write combination is present (`gwN`=0, or `bweN`=0 with some `bwN` bit at 0), `dqOe` is 0 even when `oeN`=0.
- R8: A selected cycle with no write is a read. `dqOut` carries the word one cycle later, and `dqOe`=1 in that later cycle when `oeN`=0 and no write combination is present.
- R9: In a strobe cycle the advance input is ignored. The burst offset restarts at its first position.
- R10: A non-strobe cycle with `advN`=0 moves the offset one step, wrapping after four steps. Low address bits for step k from start s: (s+k) mod 4 when `burstMode`=0 (linear), s XOR k when `burstMode`=1 (interleaved).
- R11: A non-strobe selected cycle with a write combination writes at the current burst address. The upper bits of that address come from the address that was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| adscN | input | 1 | Controller address strobe, active low |
| adspN | input | 1 | Processor address strobe, active low, has priority |
| ceN | input | 3 | Chip enables, all active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Per-lane byte selects, active low |
| advN | input | 1 | Burst advance, active low |
| burstMode | input | 1 | 0 linear order, 1 interleaved order |
| oeN | input | 1 | Output enable, active low |
| addr | input | 19 | External address |
| dqIn | input | 36 | Write data from the shared bus |
| dqOut | output | 36 | Registered read data toward the shared bus |
| dqOe | output | 1 | Drive enable for the shared bus |

## Verification
Each result falls due at a different point, and the bench samples each one there:

- **Bus-enable decision:** combinational, so it is due in the same cycle as the stimulus.
- **Write:** takes effect on the edge that ends its cycle.
- **Read data:** appears one cycle after the read.

A behavioural model in the bench follows the same timeline. Inputs are driven just after a falling edge. One nanosecond later, `dqOe` and (when it is enabled) `dqOut` are compared with the model's expectation for that cycle. The model then advances its state on the rising edge. Because of this, every cycle is checked, and each stored word is observed one cycle after the read that fetched it.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFS_W  = 2;

  typedef struct packed {
    logic             load;     // a strobe loads a new address this cycle
    logic             adv;      // step the burst offset
    logic             wrEn;     // commit a write at the edge
    logic             rdEn;     // capture read data at the edge
    logic             wrSeen;   // write combination present on the pins
    logic [LANES-1:0] byteMask; // lanes to write
  } ctrlStb_t;
endpackage

// File: rtl/bwsram_ctrl_dec.sv
module bwsram_ctrl_dec
  import bwsram_pkg::*;
#(
  parameter int NUM_CE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adscN,
  input  logic              adspN,
  input  logic [NUM_CE-1:0] ceN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              advN,
  output ctrlStb_t          stb
);
  logic selReg;
  logic selNow;
  logic strobe;
  logic allCe;
  logic combo;
  logic [LANES-1:0] mask;

  always_comb begin
    strobe = !adspN || !adscN;
    allCe  = (ceN == '0);
    selNow = strobe ? allCe : selReg;
    if (!gwN)       mask = '1;
    else if (!bweN) mask = ~bwN;
    else            mask = '0;
    combo = (mask != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       selReg <= 1'b0;
    else if (strobe) selReg <= allCe;
  end

  always_comb begin
    stb.load     = strobe;
    stb.adv      = !strobe && !advN;
    stb.wrSeen   = combo;
    stb.wrEn     = selNow && combo && adspN;
    stb.rdEn     = selNow && !(combo && adspN);
    stb.byteMask = mask;
  end

  // R4
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && (ceN != '0)) |=> (stb.load || (!stb.wrEn && !stb.rdEn)));

  // R3
  adsp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN) |-> !stb.wrEn);
endmodule

// File: rtl/bwsram_burst.sv
module bwsram_burst
  import bwsram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             adv,
  input  logic             mode,
  input  logic [OFS_W-1:0] startLo,
  output logic [OFS_W-1:0] idx
);
  logic [OFS_W-1:0] baseLo;
  logic [OFS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo <= '0;
      cnt    <= '0;
    end else if (load) begin
      baseLo <= startLo;
      cnt    <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (mode) idx = baseLo ^ cnt;
    else      idx = baseLo + cnt;
  end

  // R9
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (cnt == '0));

  // R10
  adv_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && adv) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/bwsram_dpath.sv
module bwsram_dpath
  import bwsram_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int CORE_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFS_W-1:0]  burstIdx,
  input  logic              oeN,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOe
);
  localparam int CORE_DEPTH = 1 << CORE_AW;

  logic [ADDR_W-OFS_W-1:0] hiReg;
  logic [ADDR_W-1:0]       effAddr;
  logic [CORE_AW-1:0]      coreIdx;
  logic [WORD_W-1:0]       mem [CORE_DEPTH];
  logic [WORD_W-1:0]       curWord;
  logic [WORD_W-1:0]       rdData;
  logic                    rdValid;

  always_comb begin
    effAddr = stb.load ? addr : {hiReg, burstIdx};
    coreIdx = effAddr[CORE_AW-1:0];
    curWord = mem[coreIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)         hiReg <= '0;
    else if (stb.load) hiReg <= addr[ADDR_W-1:OFS_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CORE_DEPTH; i++) mem[i] <= '0;
    end else if (stb.wrEn) begin
      for (int l = 0; l < LANES; l++)
        if (stb.byteMask[l])
          mem[coreIdx][l*LANE_W +: LANE_W] <= dqIn[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= curWord;
    end
  end

  assign dqOut = rdData;
  assign dqOe  = rdValid && !oeN && !stb.wrSeen;

  // R8
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> $past(stb.rdEn));

  // R11
  block_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (stb.load ||
      effAddr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W])));

  for (genvar g = 0; g < LANES; g++) begin : g_laneChk
    // R5
    lane_written_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrEn && stb.byteMask[g]) |=>
        (mem[$past(coreIdx)][g*LANE_W +: LANE_W] == $past(dqIn[g*LANE_W +: LANE_W])));
    // R6
    lane_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrEn && !stb.byteMask[g]) |=>
        (mem[$past(coreIdx)][g*LANE_W +: LANE_W] == $past(curWord[g*LANE_W +: LANE_W])));
  end
endmodule

// File: rtl/bwsram_ctrl.sv
module bwsram_ctrl
  import bwsram_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int CORE_AW = 8,
  parameter int NUM_CE  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adscN,
  input  logic              adspN,
  input  logic [NUM_CE-1:0] ceN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              advN,
  input  logic              burstMode,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOe
);
  ctrlStb_t         stb;
  logic [OFS_W-1:0] burstIdx;

  bwsram_ctrl_dec #(.NUM_CE(NUM_CE)) u_dec (
    .clk(clk), .rstN(rstN), .adscN(adscN), .adspN(adspN), .ceN(ceN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .advN(advN), .stb(stb)
  );

  bwsram_burst u_burst (
    .clk(clk), .rstN(rstN), .load(stb.load), .adv(stb.adv),
    .mode(burstMode), .startLo(addr[OFS_W-1:0]), .idx(burstIdx)
  );

  bwsram_dpath #(.ADDR_W(ADDR_W), .CORE_AW(CORE_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .burstIdx(burstIdx),
    .oeN(oeN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/bwsram_ctrl_tb.sv
`timescale 1ns/1ps
module bwsram_ctrl_tb;
  localparam int AW = 19;
  localparam int CAW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic adscN, adspN, gwN, bweN, advN, burstMode, oeN;
  logic [2:0] ceN;
  logic [3:0] bwN;
  logic [AW-1:0] addr;
  logic [35:0] dqIn, dqOut;
  logic dqOe;

  always #2.5 clk = ~clk;

  bwsram_ctrl u_dut (
    .clk(clk), .rstN(rstN), .adscN(adscN), .adspN(adspN), .ceN(ceN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .advN(advN), .burstMode(burstMode),
    .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  logic [35:0] mMem [1 << CAW];
  logic        mSel, mRdValid;
  logic [35:0] mRdData;
  logic [AW-1:0] mBase;
  int          mStep;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int offsetOf(input int s, input int k, input logic intl);
    return intl ? ((s ^ k) & 3) : ((s + k) & 3);
  endfunction

  task automatic idle();
    adscN = 1; adspN = 1; ceN = 3'b000; gwN = 1; bweN = 1; bwN = 4'hF;
    advN = 1; oeN = 0; dqIn = '0;
  endtask

  // one clock: check outputs for this cycle, then advance the model
  task automatic cycle(input string tag);
    logic load, selNow, combo, wr, rd, expOe;
    logic [3:0] mask;
    logic [AW-1:0] eff;
    int idx;
    #1;
    load   = !adspN || !adscN;
    selNow = load ? (ceN == 3'b000) : mSel;
    mask   = !gwN ? 4'hF : (!bweN ? ~bwN : 4'h0);
    combo  = mask != 0;
    wr     = selNow && combo && adspN;
    rd     = selNow && !wr;
    eff    = load ? addr : {mBase[AW-1:2], 2'(offsetOf(int'(mBase[1:0]), mStep, burstMode))};
    idx    = int'(eff[CAW-1:0]);
    expOe  = mRdValid && !oeN && !combo;
    chk(dqOe === expOe, tag, {35'b0, dqOe}, {35'b0, expOe});
    if (expOe) chk(dqOut === mRdData, tag, dqOut, mRdData);
    @(posedge clk);
    mRdValid = rd;
    if (rd) mRdData = mMem[idx];
    if (wr) for (int l = 0; l < 4; l++) if (mask[l]) mMem[idx][l*9 +: 9] = dqIn[l*9 +: 9];
    if (load) begin mBase = addr; mStep = 0; mSel = (ceN == 3'b000); end
    else if (!advN) mStep = (mStep + 1) & 3;
    @(negedge clk);
  endtask

  task automatic adscAccess(input logic [AW-1:0] a, input string tag);
    adscN = 0; addr = a; cycle(tag); adscN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(); burstMode = 0; addr = '0; rstN = 0;
    for (int i = 0; i < (1 << CAW); i++) mMem[i] = '0;
    mSel = 0; mRdValid = 0; mRdData = '0; mBase = '0; mStep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1 chk(dqOe === 1'b0, "R1 reset oe", {35'b0, dqOe}, 36'h0);
    // R1: unwritten word reads zero
    adscAccess(19'h00009, "R1"); cycle("R1");

    // R2 R5 R7: global write, bus released although oeN=0
    gwN = 0; bweN = 1; bwN = 4'hF; dqIn = 36'hA_BCDE_F012;
    adscAccess(19'h00005, "R7"); idle();
    adscAccess(19'h00005, "R2"); cycle("R2");

    // R6: byte write on lanes 0 and 2
    gwN = 1; bweN = 0; bwN = 4'b1010; dqIn = 36'h1_2345_6789;
    adscAccess(19'h00005, "R6"); idle();
    adscAccess(19'h00005, "R6"); cycle("R6");
    // R6: bweN high means a read even with lane selects low
    bweN = 1; bwN = 4'h0; dqIn = 36'hF_FFFF_FFFF;
    adscAccess(19'h00005, "R6"); idle(); cycle("R6");

    // R3: processor strobe blocks the write
    adspN = 0; gwN = 0; addr = 19'h00005; dqIn = 36'h0_0000_0BAD;
    cycle("R3"); idle(); cycle("R3");
    adscAccess(19'h00005, "R3"); cycle("R3");

    // R4: deselect, then burst cycles try to write and read
    gwN = 0; ceN = 3'b010; dqIn = 36'h5_5555_5555;
    adscAccess(19'h00005, "R4"); ceN = 3'b000;
    advN = 0; cycle("R4"); cycle("R4"); gwN = 1; cycle("R4"); idle();
    adscAccess(19'h00005, "R4"); cycle("R4");
    adscAccess(19'h00004, "R4"); cycle("R4");

    // R9 R10 R11: linear burst write from offset 2, advance ignored on strobe
    gwN = 0; advN = 0; dqIn = 36'h0_0000_0101;
    adscAccess(19'h00006, "R9");
    dqIn = 36'h0_0000_0202; cycle("R11");
    dqIn = 36'h0_0000_0303; cycle("R11");
    dqIn = 36'h0_0000_0404; cycle("R11");
    idle();
    // linear read back of the block from offset 2, wrapping
    advN = 0; adscAccess(19'h00006, "R10");
    for (int k = 0; k < 5; k++) cycle("R10");
    // interleaved read from offset 1
    idle(); burstMode = 1; advN = 0;
    adscAccess(19'h00005, "R10");
    for (int k = 0; k < 4; k++) cycle("R10");
    // interleaved byte-write burst from offset 3
    idle(); gwN = 1; bweN = 0; bwN = 4'b0110; advN = 0; dqIn = 36'hE_EEEE_EEEE;
    adscAccess(19'h00007, "R11"); cycle("R11");
    idle(); advN = 0; adscAccess(19'h00007, "R10");
    for (int k = 0; k < 4; k++) cycle("R10");

    // R8: oeN high hides data; write combination hides pending data
    idle(); burstMode = 0;
    adscAccess(19'h00006, "R8"); oeN = 1; cycle("R8"); oeN = 0; cycle("R8");
    adscAccess(19'h00007, "R7"); gwN = 1; bweN = 0; bwN = 4'b0111; ceN = 3'b100;
    adscAccess(19'h00000, "R7"); idle(); cycle("R7");
    // upper address bits carried through a burst
    gwN = 0; dqIn = 36'h7_0000_0007;
    adscAccess(19'h40021, "R11"); idle(); advN = 0; gwN = 0; dqIn = 36'h7_0000_0008;
    cycle("R11"); idle();
    adscAccess(19'h40022, "R11"); cycle("R11");
    adscAccess(19'h00021, "R11"); cycle("R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule